// File: doc/BRIEF.md
# Acknowledgeable Event Status Register

This block holds an 8-bit event word that the controller side uses to tell the host about things that happened asynchronously. The controller raises or drops event bits through a set strobe and a clear strobe, each with its own bit mask. The host answers through an acknowledge strobe with a mask. The acknowledge clears only the two events that the host is allowed to retire: controller reboot and windows reset. Every other bit is dropped only by the controller, once the condition it reports no longer holds.

A reboot event always carries a windows-reset event with it. The block drives a host interrupt. The interrupt rises one cycle after any bit goes from 0 to 1. It stays asserted for as long as an acknowledgeable event is pending. Each 0-to-1 transition of the windows-reset bit also gives a one-cycle pulse, which the window tracker uses to drop its active window. Command decoding happens upstream. The acknowledge reaches this block as a strobe that is already decoded.

Top module: `event_status_reg`

## Requirements
- R1: After reset the event word, the host interrupt and the windows-reset pulse are all 0.
- R2: A controller set strobe makes every bit named in its mask 1 at the next clock edge. Bits outside the mask keep their values.
- R3: A controller set that names bit 0 (reboot, value 0x01) also sets bit 1 (windows reset, value 0x02) at the same edge.
- R4: A controller clear strobe drops every bit named in its mask at the next edge. This applies to any bit position.
- R5: A host acknowledge drops only those of bits 0 and 1 that its mask names.
- R6: A host acknowledge leaves bits 2 to 7 unchanged. This includes flash control lost (bit 6, 0x40) and daemon ready (bit 7, 0x80).
- R7: When a controller set hits the same bit in the same cycle as a controller clear or a host acknowledge, the bit ends up 1.
- R8: The host interrupt is high in the cycle after any bit of the event word goes from 0 to 1.
- R9: The host interrupt stays high while bit 0 or bit 1 is set. It is low when neither bit is set and no bit rose at the last edge.
- R10: The windows-reset pulse is high for exactly the one cycle in which bit 1 has just gone from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_set_valid | input | 1 | Controller set strobe |
| ctl_set_mask | input | 8 | Bits to raise |
| ctl_clr_valid | input | 1 | Controller clear strobe |
| ctl_clr_mask | input | 8 | Bits to drop |
| host_ack_valid | input | 1 | Decoded host acknowledge strobe |
| host_ack_mask | input | 8 | Bits the host acknowledges |
| evt_status | output | 8 | Current event word |
| host_irq | output | 1 | Interrupt toward the host |
| win_reset_pulse | output | 1 | One-cycle windows-reset notification |

## Verification
The hardest case to reach is when all three strobes collide in one cycle. For example, a set of bit 1 can arrive together with a host acknowledge of bit 1 while the bit is already clear. A second case is a reboot set that arrives while windows reset is already pending. In that case the pulse must not repeat, even though the interrupt stays up. The stimulus first drives the word into a known mixed state. It then fires the set strobe together with the acknowledge or the clear strobe, with masks that overlap on purpose. It also checks the cycle after a rise, in which the interrupt falls if only non-acknowledgeable bits remain.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int EVT_W = 8;
  typedef logic [EVT_W-1:0] evt_word_t;

  // Set mask widened so that a reboot request drags windows reset along.
  function automatic evt_word_t widen_set(input evt_word_t m, input int reboot_pos,
                                          input int wrst_pos);
    evt_word_t r;
    r = m;
    if (m[reboot_pos]) r[wrst_pos] = 1'b1;
    return r;
  endfunction

  // Host acknowledge restricted to the bits it may retire.
  function automatic evt_word_t ack_filter(input evt_word_t m, input evt_word_t allowed);
    return m & allowed;
  endfunction

  // Bits that go from 0 to 1 between two words.
  function automatic evt_word_t rising_bits(input evt_word_t prev, input evt_word_t nxt);
    return nxt & ~prev;
  endfunction
endpackage

// File: rtl/evt_next.sv
module evt_next
  import evt_pkg::*;
#(
  parameter evt_word_t ACK_MASK   = 8'h03,
  parameter int        REBOOT_BIT = 0,
  parameter int        WRST_BIT   = 1
) (
  input  evt_word_t cur,
  input  logic      set_v,
  input  evt_word_t set_m,
  input  logic      clr_v,
  input  evt_word_t clr_m,
  input  logic      ack_v,
  input  evt_word_t ack_m,
  output evt_word_t nxt,
  output evt_word_t set_eff,
  output evt_word_t drop_eff
);
  evt_word_t clr_eff;
  evt_word_t ack_eff;

  always_comb begin
    set_eff  = set_v ? widen_set(set_m, REBOOT_BIT, WRST_BIT) : '0;
    clr_eff  = clr_v ? clr_m : '0;
    ack_eff  = ack_v ? ack_filter(ack_m, ACK_MASK) : '0;
    drop_eff = clr_eff | ack_eff;
    // set is applied last so it wins any collision
    nxt      = (cur & ~drop_eff) | set_eff;
  end
endmodule

// File: rtl/evt_flags.sv
module evt_flags
  import evt_pkg::*;
#(
  parameter evt_word_t ACK_MASK = 8'h03,
  parameter int        WRST_BIT = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  evt_word_t cur,
  input  evt_word_t nxt,
  output logic      irq,
  output logic      wrst_pulse,
  output evt_word_t newly_set
);
  logic pending_ack;

  always_comb begin
    newly_set   = rising_bits(cur, nxt);
    pending_ack = |(nxt & ACK_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq        <= 1'b0;
      wrst_pulse <= 1'b0;
    end else begin
      irq        <= pending_ack | (|newly_set);
      wrst_pulse <= newly_set[WRST_BIT];
    end
  end

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wrst_pulse |=> !wrst_pulse || $past(newly_set[WRST_BIT]));
endmodule

// File: rtl/event_status_reg.sv
module event_status_reg
  import evt_pkg::*;
#(
  parameter evt_word_t ACK_MASK   = 8'h03,
  parameter int        REBOOT_BIT = 0,
  parameter int        WRST_BIT   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_set_valid,
  input  logic [EVT_W-1:0] ctl_set_mask,
  input  logic             ctl_clr_valid,
  input  logic [EVT_W-1:0] ctl_clr_mask,
  input  logic             host_ack_valid,
  input  logic [EVT_W-1:0] host_ack_mask,
  output logic [EVT_W-1:0] evt_status,
  output logic             host_irq,
  output logic             win_reset_pulse
);
  evt_word_t status_q;
  evt_word_t status_d;
  evt_word_t set_eff;
  evt_word_t drop_eff;
  evt_word_t newly_set;

  evt_next #(.ACK_MASK(ACK_MASK), .REBOOT_BIT(REBOOT_BIT), .WRST_BIT(WRST_BIT)) u_next (
    .cur(status_q), .set_v(ctl_set_valid), .set_m(ctl_set_mask),
    .clr_v(ctl_clr_valid), .clr_m(ctl_clr_mask),
    .ack_v(host_ack_valid), .ack_m(host_ack_mask),
    .nxt(status_d), .set_eff(set_eff), .drop_eff(drop_eff)
  );

  evt_flags #(.ACK_MASK(ACK_MASK), .WRST_BIT(WRST_BIT)) u_flags (
    .clk(clk), .rst_n(rst_n), .cur(status_q), .nxt(status_d),
    .irq(host_irq), .wrst_pulse(win_reset_pulse), .newly_set(newly_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign evt_status = status_q;

  assert_set_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_set_valid |=> ((evt_status & $past(ctl_set_mask)) == $past(ctl_set_mask)));

  assert_reboot_drags_wrst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set_valid && ctl_set_mask[REBOOT_BIT]) |=> evt_status[WRST_BIT]);

  assert_ack_spares_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_set_valid && !ctl_clr_valid) |=>
      ((evt_status & ~ACK_MASK) == ($past(evt_status) & ~ACK_MASK)));

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_status & ACK_MASK)) |-> host_irq);

  assert_irq_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|newly_set) |=> host_irq);

  assert_pulse_tracks_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    win_reset_pulse == $rose(evt_status[WRST_BIT]));

  assert_no_spurious_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (newly_set & ~set_eff) == '0);

  assert_drop_applied_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_eff != '0) |=> ((evt_status & $past(drop_eff) & ~$past(set_eff)) == '0));
endmodule

// File: tb/event_status_reg_bench.sv
module event_status_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       set_v = 1'b0, clr_v = 1'b0, ack_v = 1'b0;
  logic [7:0] set_m = '0, clr_m = '0, ack_m = '0;
  logic [7:0] evt_status;
  logic       host_irq, win_reset_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] st;
    logic       irq;
    logic       pulse;
    string      req;
  } exp_t;
  exp_t q[$];

  logic [7:0] model = '0;

  always #2 clk = ~clk;

  event_status_reg u_event_status_reg (
    .clk(clk), .rst_n(rst_n),
    .ctl_set_valid(set_v), .ctl_set_mask(set_m),
    .ctl_clr_valid(clr_v), .ctl_clr_mask(clr_m),
    .host_ack_valid(ack_v), .host_ack_mask(ack_m),
    .evt_status(evt_status), .host_irq(host_irq), .win_reset_pulse(win_reset_pulse)
  );

  // Driver: applies one cycle of stimulus and predicts the result.
  task automatic step(input logic sv, input logic [7:0] sm, input logic cv,
                      input logic [7:0] cm, input logic av, input logic [7:0] am,
                      input string req);
    logic [7:0] s, a, c, nx;
    exp_t e;
    @(negedge clk);
    set_v = sv; set_m = sm; clr_v = cv; clr_m = cm; ack_v = av; ack_m = am;
    s = sv ? sm : 8'h00;
    if (s[0]) s = s | 8'h02;
    c = cv ? cm : 8'h00;
    a = av ? (am & 8'h03) : 8'h00;
    nx = (model & ~c & ~a) | s;
    e.st    = nx;
    e.irq   = (nx[0] | nx[1]) | (|(nx & ~model));
    e.pulse = nx[1] & ~model[1];
    e.req   = req;
    q.push_back(e);
    model = nx;
  endtask

  task automatic idle(input string req);
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, req);
  endtask

  // Monitor: compares one prediction after every edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (evt_status !== e.st || host_irq !== e.irq || win_reset_pulse !== e.pulse) begin
        fails++;
        $display("FAIL %s: got st=%h irq=%b pulse=%b, expected st=%h irq=%b pulse=%b",
                 e.req, evt_status, host_irq, win_reset_pulse, e.st, e.irq, e.pulse);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (evt_status !== 8'h00 || host_irq !== 1'b0 || win_reset_pulse !== 1'b0) begin
      fails++;
      $display("FAIL R1: got st=%h irq=%b pulse=%b, expected st=00 irq=0 pulse=0",
               evt_status, host_irq, win_reset_pulse);
    end
    rst_n = 1'b1;
    idle("R1");
    step(1'b1, 8'h80, 1'b0, 8'h00, 1'b0, 8'h00, "R8");  // daemon ready rises
    idle("R9");                                           // irq drops, no ackable bit
    step(1'b1, 8'h40, 1'b0, 8'h00, 1'b0, 8'h00, "R2");
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'hC0, "R6");  // ack on locked bits
    step(1'b1, 8'h01, 1'b0, 8'h00, 1'b0, 8'h00, "R3");  // reboot drags wrst, pulse
    idle("R10");
    idle("R9");
    step(1'b1, 8'h01, 1'b0, 8'h00, 1'b0, 8'h00, "R10"); // wrst already set: no pulse
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h01, "R5");
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'h02, "R5");
    step(1'b1, 8'h02, 1'b0, 8'h00, 1'b1, 8'h02, "R7");  // set beats ack
    step(1'b0, 8'h00, 1'b1, 8'h80, 1'b0, 8'h00, "R4");
    step(1'b1, 8'h02, 1'b1, 8'h02, 1'b0, 8'h00, "R7");  // set beats clear
    step(1'b1, 8'h3C, 1'b0, 8'h00, 1'b0, 8'h00, "R2");
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'hFF, "R6");  // only bits 0,1 drop
    idle("R9");
    step(1'b0, 8'h00, 1'b1, 8'hFF, 1'b0, 8'h00, "R4");
    step(1'b1, 8'h02, 1'b0, 8'h00, 1'b0, 8'h00, "R10");
    step(1'b0, 8'h00, 1'b1, 8'h02, 1'b0, 8'h00, "R4");
    step(1'b1, 8'h81, 1'b1, 8'h40, 1'b1, 8'h03, "R7");
    idle("R9");
    idle("R9");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule